// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Grid Scanner

This block time-multiplexes a vacuum-fluorescent panel of up to sixteen digits. It walks the enabled digits in turn, lights exactly one grid at a time together with that digit's segment pattern, and limits how long each grid is lit within its time slot. The amount of on-time is set by a 3-bit brightness code. The segment pattern comes from an external 48-byte display memory. Each digit occupies three consecutive bytes of that memory, and the block reads it through a wide combinational read port.

The digit count can be set from 8 to 16. Every digit added beyond eight takes over one segment pin as a grid, starting with the highest pin and moving down. Slot timing advances on a sub-tick enable, so the scan rate is set by whoever drives that enable. Timing keeps running while the display is dark, so a key scanner can keep using the frame strobe.

Top module: `vfdGridScanner`

## Requirements
- R1: A mode write with modeCode[3]=0 selects 8 digits and 20 segments. modeCode = 1abc selects 9+abc digits and 28 minus that digit count segments, so 1111 gives 16 digits and 12 segments.
- R2: Grid g (0-based, g from 8 to 15) is driven on segOut[27-g] whenever the digit count exceeds g. Grids 0 to 7 are driven on gridOut[g].
- R3: For digit n, memAddr equals 3n. memData[7:0] is the byte at 3n, memData[15:8] is the byte at 3n+1, and memData[19:16] is the low nibble of the byte at 3n+2. Segment pin s shows memData[s].
- R4: The brightness code 0..7 lights the grid and its segments for 1, 2, 4, 10, 11, 12, 13 or 14 sub-ticks of each slot, counted from the start of the slot. All outputs are low for the rest of the slot.
- R5: A slot lasts 16 sub-ticks. Digits run 0,1,…,N-1 and then wrap to 0. At most one grid is active at any time. Outputs are registered and show the scan state one clock later.
- R6: After reset the block uses 16 digits, the 1-sub-tick width and display off. All outputs are low.
- R7: A mode write that changes the digit count turns the display off and restarts the scan at digit 0, sub-tick 0. A mode write that selects the current digit count, including another 0xxx code while in 8-digit mode, has no effect.
- R8: With the display off, segOut and gridOut stay low while slot and frame timing continue.
- R9: frameEnd is a single-cycle pulse. It appears in the cycle after the sub-tick that closes the slot of the last active digit, so it comes once every 16·N sub-ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Load strobe for modeCode |
| modeCode | input | 4 | Digit-count code |
| ctrlWr | input | 1 | Load strobe for ctrlOn and ctrlDim |
| ctrlOn | input | 1 | Display enable |
| ctrlDim | input | 3 | Brightness code |
| subTick | input | 1 | Advances slot timing by one sub-tick |
| memAddr | output | 6 | Address of the first byte of the current digit |
| memData | input | 20 | Pattern bytes for memAddr, read combinationally |
| segOut | output | 20 | Segment lines; the upper lines serve as grids 9..16 |
| gridOut | output | 8 | Dedicated grid lines 1..8 |
| frameEnd | output | 1 | One-cycle end-of-frame strobe |

## Verification
Suppose the sub-tick or digit counter goes wrong. The lit grid then lands on the wrong pin, or the on-window changes length, within a single slot, and frameEnd moves by whole slots in the first frame. A stale or wrong digit count shows up as segment pins that light as data when they should be grids (or the reverse), and as a different frame period. A display-enable bit that fails to clear after a mode change leaves lit pins visible one clock after the write.

// File: rtl/vfdScanPkg.sv
`timescale 1ns/1ps
package vfdScanPkg;
  localparam int NUM_SEG_PINS    = 20;
  localparam int BASE_GRIDS      = 8;
  localparam int MAX_DIGITS      = 16;
  localparam int SUB_PER_SLOT    = 16;
  localparam int BYTES_PER_DIGIT = 3;
  localparam int MIN_SEGS        = NUM_SEG_PINS - (MAX_DIGITS - BASE_GRIDS);
  localparam int DIG_W           = $clog2(MAX_DIGITS);
  localparam int CNT_W           = $clog2(MAX_DIGITS + 1);
  localparam int SUB_W           = $clog2(SUB_PER_SLOT);
  localparam int ADDR_W          = $clog2(MAX_DIGITS * BYTES_PER_DIGIT);

  // strobes from scan control to the pin datapath
  typedef struct packed {
    logic             lit;
    logic [DIG_W-1:0] digit;
    logic [CNT_W-1:0] numDig;
  } scanStrobeT;

  function automatic logic [SUB_W:0] dimWidth(input logic [2:0] code);
    case (code)
      3'd0:    dimWidth = (SUB_W+1)'(1);
      3'd1:    dimWidth = (SUB_W+1)'(2);
      3'd2:    dimWidth = (SUB_W+1)'(4);
      default: dimWidth = (SUB_W+1)'(7) + (SUB_W+1)'(code);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decodeDigits(input logic [3:0] code);
    if (code[3]) decodeDigits = CNT_W'(BASE_GRIDS + 1) + CNT_W'(code[2:0]);
    else         decodeDigits = CNT_W'(BASE_GRIDS);
  endfunction
endpackage

// File: rtl/scanCtrl.sv
`timescale 1ns/1ps
module scanCtrl
  import vfdScanPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic [3:0] modeCode,
  input  logic       ctrlWr,
  input  logic       ctrlOn,
  input  logic [2:0] ctrlDim,
  input  logic       subTick,
  output scanStrobeT strb,
  output logic       frameEnd
);
  logic [SUB_W-1:0] subCnt;
  logic [DIG_W-1:0] digIdx;
  logic [CNT_W-1:0] numDig;
  logic             onReg;
  logic [2:0]       dimReg;

  logic [CNT_W-1:0] newNum;
  logic             modeChange;
  logic             slotEnd;
  logic             lastDig;

  assign newNum     = decodeDigits(modeCode);
  assign modeChange = modeWr && (newNum != numDig);
  assign slotEnd    = subTick && (subCnt == SUB_W'(SUB_PER_SLOT - 1));
  assign lastDig    = (CNT_W'(digIdx) == numDig - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt   <= '0;
      digIdx   <= '0;
      numDig   <= CNT_W'(MAX_DIGITS);
      onReg    <= 1'b0;
      dimReg   <= 3'd0;
      frameEnd <= 1'b0;
    end else begin
      frameEnd <= slotEnd && lastDig && !modeChange;
      if (ctrlWr) begin
        onReg  <= ctrlOn;
        dimReg <= ctrlDim;
      end
      if (modeChange) begin
        // a new digit count blanks the panel and restarts the scan
        numDig <= newNum;
        onReg  <= 1'b0;
        subCnt <= '0;
        digIdx <= '0;
      end else if (subTick) begin
        if (slotEnd) begin
          subCnt <= '0;
          digIdx <= lastDig ? '0 : digIdx + DIG_W'(1);
        end else begin
          subCnt <= subCnt + SUB_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb.lit    = onReg && ({1'b0, subCnt} < dimWidth(dimReg));
    strb.digit  = digIdx;
    strb.numDig = numDig;
  end
endmodule

// File: rtl/scanDatapath.sv
`timescale 1ns/1ps
module scanDatapath
  import vfdScanPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  scanStrobeT              strb,
  input  logic [NUM_SEG_PINS-1:0] memData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [NUM_SEG_PINS-1:0] segOut,
  output logic [BASE_GRIDS-1:0]   gridOut
);
  logic [MAX_DIGITS-1:0]   gridVec;
  logic [NUM_SEG_PINS-1:0] segNext;

  assign memAddr = ADDR_W'(strb.digit) * ADDR_W'(BYTES_PER_DIGIT);
  assign gridVec = strb.lit ? (MAX_DIGITS'(1) << strb.digit) : '0;

  for (genvar s = 0; s < NUM_SEG_PINS; s++) begin : g_pin
    if (s < MIN_SEGS) begin : g_seg
      assign segNext[s] = strb.lit & memData[s];
    end else begin : g_dual
      localparam int GRID_IDX = BASE_GRIDS + NUM_SEG_PINS - 1 - s;
      logic asGrid;
      assign asGrid     = strb.numDig > CNT_W'(GRID_IDX);
      assign segNext[s] = asGrid ? gridVec[GRID_IDX] : (strb.lit & memData[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segOut  <= '0;
      gridOut <= '0;
    end else begin
      segOut  <= segNext;
      gridOut <= gridVec[BASE_GRIDS-1:0];
    end
  end
endmodule

// File: rtl/vfdGridScanner.sv
`timescale 1ns/1ps
module vfdGridScanner
  import vfdScanPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    modeWr,
  input  logic [3:0]              modeCode,
  input  logic                    ctrlWr,
  input  logic                    ctrlOn,
  input  logic [2:0]              ctrlDim,
  input  logic                    subTick,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic [NUM_SEG_PINS-1:0] memData,
  output logic [NUM_SEG_PINS-1:0] segOut,
  output logic [BASE_GRIDS-1:0]   gridOut,
  output logic                    frameEnd
);
  scanStrobeT strb;

  scanCtrl ctrlI (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeCode(modeCode),
    .ctrlWr(ctrlWr), .ctrlOn(ctrlOn), .ctrlDim(ctrlDim),
    .subTick(subTick), .strb(strb), .frameEnd(frameEnd)
  );

  scanDatapath dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData),
    .memAddr(memAddr), .segOut(segOut), .gridOut(gridOut)
  );
endmodule

// File: rtl/vfdGridScannerChk.sv
`timescale 1ns/1ps
module vfdGridScannerChk
  import vfdScanPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    modeWr,
  input logic [3:0]              modeCode,
  input logic [ADDR_W-1:0]       memAddr,
  input logic [NUM_SEG_PINS-1:0] segOut,
  input logic [BASE_GRIDS-1:0]   gridOut,
  input logic                    frameEnd,
  input scanStrobeT              strb
);
  p_grid_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gridOut));

  p_unlit_dark_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lit |=> (gridOut == '0 && segOut == '0));

  p_frame_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);

  p_mode_forces_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && decodeDigits(modeCode) != strb.numDig) |=> !strb.lit);

  p_digit_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(strb.digit) < strb.numDig);

  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    memAddr <= ADDR_W'((MAX_DIGITS - 1) * BYTES_PER_DIGIT));
endmodule

bind vfdGridScanner vfdGridScannerChk chkI (
  .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeCode(modeCode),
  .memAddr(memAddr), .segOut(segOut), .gridOut(gridOut),
  .frameEnd(frameEnd), .strb(strb)
);

// File: tb/vfdGridScanner_tb_top.sv
`timescale 1ns/1ps
module vfdGridScanner_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        modeWr, ctrlWr, ctrlOn, subTick;
  logic [3:0]  modeCode;
  logic [2:0]  ctrlDim;
  logic [5:0]  memAddr;
  logic [19:0] memData;
  logic [19:0] segOut;
  logic [7:0]  gridOut;
  logic        frameEnd;

  always #2.5 clk = ~clk;

  vfdGridScanner dut_i (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeCode(modeCode),
    .ctrlWr(ctrlWr), .ctrlOn(ctrlOn), .ctrlDim(ctrlDim), .subTick(subTick),
    .memAddr(memAddr), .memData(memData), .segOut(segOut),
    .gridOut(gridOut), .frameEnd(frameEnd)
  );

  // display memory model (R3 byte layout)
  logic [7:0] mem [0:47];
  always_comb begin
    int a;
    a = int'(memAddr);
    if (a <= 45) memData = {mem[a+2][3:0], mem[a+1], mem[a]};
    else         memData = '0;
  end

  int total = 0;
  int bad   = 0;
  int expN = 16, expW = 1;
  bit expOn = 0;

  // bench tick counter: k counts sub-ticks since scan (re)start
  int   k, kPrev;
  logic tickPrev, restartReq;
  always @(posedge clk) begin
    if (!rstN) begin
      k <= 0; kPrev <= 0; tickPrev <= 1'b0;
    end else begin
      kPrev    <= k;
      tickPrev <= subTick;
      k        <= restartReq ? 0 : (subTick ? k + 1 : k);
    end
  end

  int tickDiv = 1;
  int tc = 0;
  bit tickRun = 0;
  always @(negedge clk) begin
    if (!tickRun) begin
      subTick <= 1'b0; tc <= 0;
    end else begin
      subTick <= (tc == 0);
      tc      <= (tc + 1 >= tickDiv) ? 0 : tc + 1;
    end
  end

  function automatic int dimW(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 10;
      3'd4: return 11; 3'd5: return 12; 3'd6: return 13; default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic setMode(input logic [3:0] c);
    int n;
    n = c[3] ? 9 + int'(c[2:0]) : 8;
    @(negedge clk);
    modeWr = 1'b1; modeCode = c;
    if (n != expN) begin
      restartReq = 1'b1; expN = n; expOn = 0;
    end
    @(negedge clk);
    modeWr = 1'b0; restartReq = 1'b0;
  endtask

  task automatic setCtrl(input bit on, input logic [2:0] d);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlOn = on; ctrlDim = d;
    expOn = on; expW = dimW(d);
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  // compare every cycle against the model; report first mismatch text
  string firstBad;
  task automatic runWindow(input int cycles, output int mism, output int litCnt,
                           output int frames);
    mism = 0; litCnt = 0; frames = 0; firstBad = "";
    repeat (cycles) begin
      logic [19:0] es, pat;
      logic [7:0]  eg;
      logic        ef;
      logic [5:0]  ea;
      int dig, sub, segCnt, digNow;
      bit act;
      @(negedge clk);
      dig    = (kPrev / 16) % expN;
      sub    = kPrev % 16;
      digNow = (k / 16) % expN;
      act    = expOn && (sub < expW);
      segCnt = 28 - expN;
      pat    = {mem[3*dig+2][3:0], mem[3*dig+1], mem[3*dig]};
      es = '0; eg = '0;
      if (act) begin
        for (int s = 0; s < segCnt; s++) es[s] = pat[s];
        if (dig < 8) eg[dig] = 1'b1;
        else         es[27-dig] = 1'b1;
      end
      ef = tickPrev && (((kPrev + 1) % (16 * expN)) == 0);
      ea = 6'(3 * digNow);
      if (segOut != '0 || gridOut != '0) litCnt++;
      if (frameEnd) frames++;
      if (segOut !== es || gridOut !== eg || frameEnd !== ef || memAddr !== ea) begin
        if (mism == 0)
          firstBad = $sformatf("seg=%h/%h grid=%h/%h fe=%b/%b addr=%0d/%0d (act/exp)",
                               segOut, es, gridOut, eg, frameEnd, ef, memAddr, ea);
        mism++;
      end
    end
  endtask

  // stimulus vectors: {modeCode[3:0], on, dim[2:0], tickDiv[1:0]}
  localparam logic [9:0] VEC [9] = '{
    10'b1111_1_000_01, 10'b0000_1_111_01, 10'b0101_1_011_10,
    10'b1000_1_010_01, 10'b1011_1_001_11, 10'b1101_1_100_01,
    10'b1110_1_101_10, 10'b1111_1_110_01, 10'b1001_0_111_01
  };

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mism, litCnt, frames;
    for (int i = 0; i < 48; i++) mem[i] = 8'((i * 53 + 17) ^ (i << 2));
    rstN = 1'b0; modeWr = 0; ctrlWr = 0; ctrlOn = 0; ctrlDim = 0;
    modeCode = 4'hF; restartReq = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(segOut == '0 && gridOut == '0 && frameEnd == 1'b0,
        $sformatf("R6 reset outputs seg=%h grid=%h fe=%b expected 0", segOut, gridOut, frameEnd));

    // R6 / R8: default 16 digits dark, frame timing keeps running
    tickRun = 1;
    repeat (2) @(negedge clk);
    runWindow(16 * 16 * 2 + 8, mism, litCnt, frames);
    chk(mism == 0 && frames == 2 && litCnt == 0,
        $sformatf("R6 R8 default scan mism=%0d frames=%0d/2 lit=%0d/0 %s",
                  mism, frames, litCnt, firstBad));

    // R1 R2 R3 R4 R5 vector walk
    for (int i = 0; i < 9; i++) begin
      tickDiv = int'(VEC[i][1:0]);
      setMode(VEC[i][9:6]);
      setCtrl(VEC[i][5], VEC[i][4:2]);
      repeat (2) @(negedge clk);
      runWindow(16 * expN * tickDiv + 8, mism, litCnt, frames);
      chk(mism == 0 && (litCnt > 0) == VEC[i][5],
          $sformatf("R1 R2 R3 R4 R5 vector %0d mism=%0d lit=%0d %s", i, mism, litCnt, firstBad));
      chk(frames >= 1, $sformatf("R9 vector %0d frames=%0d expected >=1", i, frames));
    end

    // R7: same digit count leaves the display running
    tickDiv = 1;
    setMode(4'b1111);
    setCtrl(1, 3'b111);
    setMode(4'b1111);
    repeat (2) @(negedge clk);
    runWindow(16 * 16 + 8, mism, litCnt, frames);
    chk(mism == 0 && litCnt > 0,
        $sformatf("R7 same code mism=%0d lit=%0d expected lit %s", mism, litCnt, firstBad));
    setMode(4'b0000);
    setCtrl(1, 3'b011);
    setMode(4'b0110);
    repeat (2) @(negedge clk);
    runWindow(16 * 8 + 8, mism, litCnt, frames);
    chk(mism == 0 && litCnt > 0,
        $sformatf("R7 equivalent 0xxx code mism=%0d lit=%0d %s", mism, litCnt, firstBad));

    // R7 / R8: new count blanks the panel, restarts, timing continues
    setMode(4'b1010);
    repeat (2) @(negedge clk);
    runWindow(16 * 11 + 8, mism, litCnt, frames);
    chk(mism == 0 && litCnt == 0 && frames == 1,
        $sformatf("R7 R8 forced off mism=%0d lit=%0d/0 frames=%0d/1 %s",
                  mism, litCnt, frames, firstBad));

    // R9: exact pulse count over three 8-digit frames
    setMode(4'b0000);
    setCtrl(1, 3'b010);
    repeat (2) @(negedge clk);
    runWindow(16 * 8 * 3, mism, litCnt, frames);
    chk(mism == 0 && frames == 3,
        $sformatf("R9 frame pulses=%0d expected 3 mism=%0d %s", frames, mism, firstBad));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule